// File: doc/BRIEF.md
# Synchronous Character Receiver with Fill and Escape Stripping

This block is the receive half of a character-oriented synchronous line controller. Serial data arrives one bit per cycle in which the bit-enable strobe is high, least significant bit first, and is gathered into characters of 5 to 8 bits. Character boundaries are taken as already aligned; the first bit after the receiver is enabled starts a character. When receive parity is in use, one parity bit follows the data bits.

Each finished character is compared with a programmable fill (idle) value and a programmable escape value. If stripping of either kind is switched on, a matching character is dropped instead of being delivered. The fill and escape events are then reported with the next character that is delivered, rather than with the dropped character itself. Delivered characters go to a holding register that the host empties with a read strobe. The block keeps data-ready, overrun, a combined parity-error / escape-seen flag and a fill-detect flag, and it raises a data request while the holding register is full.

Top module: `sync_rx_strip`

## Requirements
- R1: Bits are sampled only in cycles with `bit_en` high and are placed LSB first; `len_sel` gives the data length as 8 minus its value (0 = 8 bits, 3 = 5 bits); unused upper bits of `hold_data` read as zero.
- R2: A delivered character is written to `hold_data` and sets `data_ready`; `data_req_in` is high exactly while `data_ready` is set and `rx_en` is high.
- R3: A `host_rd` pulse with no character arriving in that cycle clears `data_ready` and leaves `hold_data` unchanged.
- R4: `overrun` is set when a character is delivered while `data_ready` is still set and no read occurs in the same cycle; any other delivery clears it.
- R5: With `syn_strip_en` high, a character equal to `syn_val` is not delivered and changes no status bit; `syn_det` of the next delivered character is 1, and 0 when no fill was dropped before it.
- R6: With `syn_strip_en` low, `syn_det` is updated on each delivery to 1 if the character equals `syn_val`, else 0.
- R7: With `dle_strip_en` high, a character equal to `dle_val` is not delivered, no parity bit is expected, and `par_dle_flag` of the next delivered character is 1 if an escape was dropped before it, else 0.
- R8: With `parity_en` high and `dle_strip_en` low, one parity bit follows the data; `par_dle_flag` is set on delivery when the ones count of data plus parity is odd (`parity_odd` = 0) or even (`parity_odd` = 1); without parity it is 0.
- R9: While `rx_en` is low, `data_ready`, `overrun`, `par_dle_flag`, `syn_det` and the pending strip events are cleared and any partial character is dropped; reset does the same.
- R10: Fill and escape comparisons use only the active data bits, ignoring upper bits of `syn_val` and `dle_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| bit_en | input | 1 | Bit-time strobe, one cycle per bit |
| rx_bit | input | 1 | Serial receive data |
| len_sel | input | 2 | Data length select, length = 8 - value |
| parity_en | input | 1 | Receive parity check enable |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| syn_strip_en | input | 1 | Drop characters equal to the fill value |
| dle_strip_en | input | 1 | Drop characters equal to the escape value |
| syn_val | input | 8 | Fill character value |
| dle_val | input | 8 | Escape character value |
| host_rd | input | 1 | Host read of the holding register |
| hold_data | output | 8 | Holding register |
| data_ready | output | 1 | Holding register full |
| overrun | output | 1 | Previous character lost |
| par_dle_flag | output | 1 | Parity error, or escape dropped when escape stripping is on |
| syn_det | output | 1 | Fill detected |
| data_req_in | output | 1 | Data request to the host |

## Verification
The host read and the delivery of a new character can land on the same clock edge. The bench provokes this by raising `host_rd` in the cycle right after the last bit is sampled, which is the cycle in which the finished character reaches the status logic. The expected outcome is that the delivery wins: `data_ready` stays set with the new data and `overrun` is clear, since the old character was taken. The random phase repeats this pairing at random, and it also pairs a read with a dropped character, where the read must clear `data_ready`.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int DW  = 8;
    localparam int LSW = 2;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          perr;
    } rx_char_t;

    typedef enum logic [1:0] {
        EV_DELIVER  = 2'd0,
        EV_DROP_SYN = 2'd1,
        EV_DROP_DLE = 2'd2
    } rx_event_e;

    function automatic logic [LSW+1:0] len_of(input logic [LSW-1:0] sel);
        return (LSW+2)'(DW) - (LSW+2)'(sel);
    endfunction

    function automatic logic [DW-1:0] mask_of(input logic [LSW-1:0] sel);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++)
            m[i] = (i < int'(len_of(sel)));
        return m;
    endfunction
endpackage

// File: rtl/sr_assembler.sv
module sr_assembler
    import sr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_en,
    input  logic           bit_en,
    input  logic           rx_bit,
    input  logic [LSW-1:0] len_sel,
    input  logic           par_on,
    input  logic           parity_odd,
    output logic           chv,
    output rx_char_t       ch
);
    localparam int IW = $clog2(DW + 2);

    logic [IW-1:0]   idx;
    logic [DW-1:0]   acc;
    logic [DW-1:0]   acc_nx;
    logic [DW-1:0]   mask;
    logic [IW-1:0]   nbits;
    logic [IW-1:0]   last_idx;

    always_comb begin
        mask     = mask_of(len_sel);
        nbits    = IW'(len_of(len_sel));
        last_idx = par_on ? nbits : nbits - 1'b1;
        acc_nx   = acc;
        if (idx < nbits)
            acc_nx[idx[$clog2(DW)-1:0]] = rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            idx <= '0;
            acc <= '0;
            chv <= 1'b0;
            ch  <= '0;
        end else begin
            chv <= 1'b0;
            if (bit_en) begin
                if (idx == last_idx) begin
                    chv     <= 1'b1;
                    ch.data <= acc_nx & mask;
                    ch.perr <= par_on && ((^(acc_nx & mask) ^ rx_bit) != parity_odd);
                    idx     <= '0;
                    acc     <= '0;
                end else begin
                    idx <= idx + 1'b1;
                    acc <= acc_nx;
                end
            end
        end
    end
endmodule

// File: rtl/sr_status.sv
module sr_status
    import sr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          chv,
    input  rx_char_t      ch,
    input  logic [DW-1:0] mask,
    input  logic          syn_strip_en,
    input  logic          dle_strip_en,
    input  logic [DW-1:0] syn_val,
    input  logic [DW-1:0] dle_val,
    input  logic          host_rd,
    output logic [DW-1:0] hold_data,
    output logic          data_ready,
    output logic          overrun,
    output logic          par_dle_flag,
    output logic          syn_det
);
    logic      is_syn;
    logic      is_dle;
    logic      pend_syn;
    logic      pend_dle;
    rx_event_e ev;

    always_comb begin
        is_syn = ((ch.data ^ syn_val) & mask) == '0;
        is_dle = ((ch.data ^ dle_val) & mask) == '0;
        if (syn_strip_en && is_syn)
            ev = EV_DROP_SYN;
        else if (dle_strip_en && is_dle)
            ev = EV_DROP_DLE;
        else
            ev = EV_DELIVER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data    <= '0;
            data_ready   <= 1'b0;
            overrun      <= 1'b0;
            par_dle_flag <= 1'b0;
            syn_det      <= 1'b0;
            pend_syn     <= 1'b0;
            pend_dle     <= 1'b0;
        end else if (!rx_en) begin
            data_ready   <= 1'b0;
            overrun      <= 1'b0;
            par_dle_flag <= 1'b0;
            syn_det      <= 1'b0;
            pend_syn     <= 1'b0;
            pend_dle     <= 1'b0;
        end else begin
            if (host_rd)
                data_ready <= 1'b0;
            if (chv) begin
                case (ev)
                    EV_DROP_SYN: pend_syn <= 1'b1;
                    EV_DROP_DLE: pend_dle <= 1'b1;
                    default: begin
                        hold_data    <= ch.data;
                        data_ready   <= 1'b1;
                        overrun      <= data_ready && !host_rd;
                        syn_det      <= syn_strip_en ? pend_syn : is_syn;
                        par_dle_flag <= dle_strip_en ? pend_dle : ch.perr;
                        pend_syn     <= 1'b0;
                        pend_dle     <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sync_rx_strip.sv
module sync_rx_strip
    import sr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_en,
    input  logic           bit_en,
    input  logic           rx_bit,
    input  logic [LSW-1:0] len_sel,
    input  logic           parity_en,
    input  logic           parity_odd,
    input  logic           syn_strip_en,
    input  logic           dle_strip_en,
    input  logic [DW-1:0]  syn_val,
    input  logic [DW-1:0]  dle_val,
    input  logic           host_rd,
    output logic [DW-1:0]  hold_data,
    output logic           data_ready,
    output logic           overrun,
    output logic           par_dle_flag,
    output logic           syn_det,
    output logic           data_req_in
);
    logic     char_vld;
    rx_char_t char_q;
    logic     par_on;

    assign par_on = parity_en && !dle_strip_en;

    sr_assembler u_asm (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
        .len_sel(len_sel), .par_on(par_on), .parity_odd(parity_odd),
        .chv(char_vld), .ch(char_q)
    );

    sr_status u_stat (
        .clk(clk), .rst(rst), .rx_en(rx_en), .chv(char_vld), .ch(char_q),
        .mask(mask_of(len_sel)), .syn_strip_en(syn_strip_en),
        .dle_strip_en(dle_strip_en), .syn_val(syn_val), .dle_val(dle_val),
        .host_rd(host_rd), .hold_data(hold_data), .data_ready(data_ready),
        .overrun(overrun), .par_dle_flag(par_dle_flag), .syn_det(syn_det)
    );

    assign data_req_in = data_ready && rx_en;
endmodule

// File: rtl/sr_checker.sv
module sr_checker (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic host_rd,
    input logic chv,
    input logic data_ready,
    input logic overrun,
    input logic par_dle_flag,
    input logic syn_det,
    input logic data_req_in
);
    assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        data_req_in |-> (rx_en && data_ready));

    assert_load_from_char_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(chv));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !chv) |=> !data_ready);

    assert_overrun_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> (data_ready && $past(data_ready)));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!data_ready && !overrun && !par_dle_flag && !syn_det));
endmodule

bind sync_rx_strip sr_checker u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .host_rd(host_rd), .chv(char_vld),
    .data_ready(data_ready), .overrun(overrun), .par_dle_flag(par_dle_flag),
    .syn_det(syn_det), .data_req_in(data_req_in)
);

// File: tb/test_sync_rx_strip.sv
`timescale 1ns/1ps
module test_sync_rx_strip;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic parity_en = 1'b0, parity_odd = 1'b0;
    logic syn_strip_en = 1'b0, dle_strip_en = 1'b0;
    logic [7:0] syn_val = 8'h16, dle_val = 8'h10;
    logic host_rd = 1'b0;
    logic [7:0] hold_data;
    logic data_ready, overrun, par_dle_flag, syn_det, data_req_in;

    int n_chk = 0, n_err = 0;
    logic [7:0] m_hold = 8'h00;
    logic m_dr = 0, m_ov = 0, m_pd = 0, m_sd = 0, m_psyn = 0, m_pdle = 0;

    always #4 clk = ~clk;

    sync_rx_strip i_sync_rx_strip (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
        .len_sel(len_sel), .parity_en(parity_en), .parity_odd(parity_odd),
        .syn_strip_en(syn_strip_en), .dle_strip_en(dle_strip_en),
        .syn_val(syn_val), .dle_val(dle_val), .host_rd(host_rd),
        .hold_data(hold_data), .data_ready(data_ready), .overrun(overrun),
        .par_dle_flag(par_dle_flag), .syn_det(syn_det), .data_req_in(data_req_in)
    );

    function automatic int nbits_of(input logic [1:0] s);
        return 8 - int'(s);
    endfunction

    function automatic logic [7:0] mask_f(input logic [1:0] s);
        return 8'hFF >> s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " hold_data"}, 32'(hold_data), 32'(m_hold));
        chk({tag, " data_ready"}, 32'(data_ready), 32'(m_dr));
        chk({tag, " overrun"}, 32'(overrun), 32'(m_ov));
        chk({tag, " par_dle_flag"}, 32'(par_dle_flag), 32'(m_pd));
        chk({tag, " syn_det"}, 32'(syn_det), 32'(m_sd));
        chk({tag, " data_req_in R2"}, 32'(data_req_in), 32'(m_dr && rx_en));
    endtask

    task automatic model_char(input logic [7:0] d, input logic perr, input logic rd_same);
        logic [7:0] m = mask_f(len_sel);
        logic is_syn = ((d ^ syn_val) & m) == 0;
        logic is_dle = ((d ^ dle_val) & m) == 0;
        if (syn_strip_en && is_syn) begin
            m_psyn = 1;
            if (rd_same) m_dr = 0;
        end else if (dle_strip_en && is_dle) begin
            m_pdle = 1;
            if (rd_same) m_dr = 0;
        end else begin
            m_ov   = m_dr && !rd_same;
            m_dr   = 1;
            m_hold = d & m;
            m_sd   = syn_strip_en ? m_psyn : is_syn;
            m_pd   = dle_strip_en ? m_pdle : perr;
            m_psyn = 0;
            m_pdle = 0;
        end
    endtask

    task automatic send(input logic [7:0] d, input logic rd_same, input logic bad_par);
        int n = nbits_of(len_sel);
        logic [7:0] dm = d & mask_f(len_sel);
        logic par_on = parity_en && !dle_strip_en;
        logic pbit = (parity_odd ? ~(^dm) : ^dm) ^ bad_par;
        for (int i = 0; i < n + (par_on ? 1 : 0); i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = (i < n) ? dm[i] : pbit;
            @(negedge clk);
            bit_en = 1'b0;
            rx_bit = ~rx_bit;
            if (i == n - 1 + (par_on ? 1 : 0) && rd_same) host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
        end
        repeat (2) @(negedge clk);
        model_char(d, par_on && bad_par, rd_same);
    endtask

    task automatic do_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        m_dr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1931));
        repeat (3) @(negedge clk);
        chk_all("reset R9");
        rst = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
        chk_all("enabled idle R9");

        send(8'hA5, 0, 0); chk_all("8-bit char R1 R2");
        // a strobe-less period must not shift anything in (R1)
        rx_bit = 1'b1; repeat (6) @(negedge clk);
        do_read(); chk_all("read clears R3");
        send(8'h3C, 0, 0); send(8'hC3, 0, 0); chk_all("overrun set R4");
        do_read(); send(8'h5A, 0, 0); chk_all("overrun cleared R4");
        do_read();

        len_sel = 2'd3; send(8'hFF, 0, 0); chk_all("5-bit upper zero R1");
        do_read();
        len_sel = 2'd0;

        syn_strip_en = 1'b1;
        send(8'h16, 0, 0); chk_all("fill dropped R5");
        send(8'h41, 0, 0); chk_all("fill reported next R5");
        chk("syn_det after drop R5", 32'(syn_det), 32'd1);
        do_read(); send(8'h42, 0, 0); chk_all("fill flag clears R5");
        syn_strip_en = 1'b0;
        do_read(); send(8'h16, 0, 0); chk_all("fill kept, detected R6");
        chk("syn_det direct R6", 32'(syn_det), 32'd1);

        do_read();
        dle_strip_en = 1'b1; parity_en = 1'b1;
        send(8'h10, 0, 0); chk_all("escape dropped R7");
        send(8'h33, 0, 0); chk_all("escape reported next R7");
        chk("par_dle_flag escape R7", 32'(par_dle_flag), 32'd1);
        do_read(); send(8'h34, 0, 0); chk_all("escape flag clears R7");
        dle_strip_en = 1'b0;

        do_read(); send(8'h07, 0, 1); chk_all("even parity bad R8");
        chk("par err even R8", 32'(par_dle_flag), 32'd1);
        do_read(); send(8'h07, 0, 0); chk_all("even parity good R8");
        parity_odd = 1'b1;
        do_read(); send(8'h6E, 0, 1); chk_all("odd parity bad R8");
        do_read(); send(8'h6E, 0, 0); chk_all("odd parity good R8");
        parity_en = 1'b0; parity_odd = 1'b0;

        do_read();
        len_sel = 2'd2; syn_val = 8'hD6; syn_strip_en = 1'b1;
        send(8'h16, 0, 0); chk_all("masked fill compare R10");
        chk("masked drop R10", 32'(data_ready), 32'd0);
        send(8'h2A, 0, 0); chk_all("masked fill reported R10");
        syn_strip_en = 1'b0; len_sel = 2'd0; syn_val = 8'h16;

        send(8'h99, 1, 0); chk_all("read and load same edge R4");
        chk("same-edge overrun clear R4", 32'(overrun), 32'd0);

        send(8'h77, 0, 0);
        @(negedge clk); rx_en = 1'b0;
        m_dr = 0; m_ov = 0; m_pd = 0; m_sd = 0; m_psyn = 0; m_pdle = 0;
        @(negedge clk); chk_all("disable clears R9");
        rx_en = 1'b1;

        for (int k = 0; k < 300; k++) begin
            logic [7:0] d;
            len_sel      = 2'($urandom_range(0, 3));
            parity_en    = 1'($urandom);
            parity_odd   = 1'($urandom);
            syn_strip_en = 1'($urandom);
            dle_strip_en = 1'($urandom);
            d = 8'($urandom);
            case ($urandom_range(0, 3))
                0: d = syn_val;
                1: d = dle_val;
                default: ;
            endcase
            send(d, 1'($urandom_range(0, 3) == 0), 1'($urandom));
            chk_all("random R1 R4 R5 R6 R7 R8 R10");
            if ($urandom_range(0, 2) == 0) begin
                do_read();
                chk_all("random read R3");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule